// File: doc/BRIEF.md
# Halt State and Interrupt Exit Controller

This block holds a processor core in its halt state after a halt instruction has been executed. While halted, the core keeps running ordinary opcode-fetch cycles so that dynamic memory refresh goes on. The block replaces the fetched byte with a no-operation code and holds the program counter still. The halt-acknowledge output stays high for the whole stay.

The interrupt inputs are sampled only on clock edges at which the cycle sequencer marks the fourth state of a fetch cycle. When such a sample shows a pending nonmaskable interrupt, or an enabled maskable one, the block raises a one-clock acknowledge request of the winning kind. It leaves the halt state on the next edge, so the interrupt-acknowledge cycle follows directly. The nonmaskable input is edge-triggered and its pending latch lasts until it is acknowledged. The maskable input is level-sensitive.

Top module: `halt_exit_ctl`

## Requirements
- R1: While reset (rst_n low) is applied and after it is released, halt_ack, force_nop, nmi_ack and int_ack are 0, no nonmaskable event is pending, and exec_op equals fetch_op.
- R2: A rising clock edge with halt_go high sets halt_ack and force_nop to 1 from the next cycle on. Both stay 1 until an exit takes place.
- R3: While force_nop is 1, exec_op is NOP_CODE (default 8'h00) whatever fetch_op is. Otherwise exec_op equals fetch_op.
- R4: Interrupt inputs are acted on only at rising edges where t4 is 1. A maskable request present only at edges with t4 at 0 leaves the halt state unchanged.
- R5: A high-to-low transition of nmi_n latches a pending event. At the first halted t4 edge with the event pending, nmi_ack is 1 for exactly one cycle, even when int_en is 0. At the end of that cycle halt_ack falls and the pending event is cleared.
- R6: int_n at 0 with int_en at 1 at a halted t4 edge raises int_ack for exactly one cycle, with halt_ack still 1. halt_ack falls at the next edge.
- R7: int_n at 0 while int_en is 0 never raises int_ack and never ends the halt state.
- R8: When a nonmaskable event is pending and an enabled maskable request is present at the same t4 sample, only nmi_ack is raised. nmi_ack and int_ack are never 1 together.
- R9: A pending nonmaskable event survives while the core is not halted and ends the next halt at its first t4 edge. nmi_n held low after acknowledge creates no new event.
- R10: halt_go while already halted has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_go | input | 1 | One-clock pulse: halt instruction executed |
| nmi_n | input | 1 | Nonmaskable interrupt, active low, edge-triggered |
| int_n | input | 1 | Maskable interrupt, active low, level-sensitive |
| int_en | input | 1 | Maskable interrupt enable flag |
| t4 | input | 1 | Marks the fourth state of a fetch cycle |
| fetch_op | input | OPW | Byte fetched from memory |
| exec_op | output | OPW | Opcode handed to the decoder |
| halt_ack | output | 1 | Halt acknowledge, high while halted |
| force_nop | output | 1 | NOP forced and program counter held |
| nmi_ack | output | 1 | One-clock nonmaskable acknowledge request |
| int_ack | output | 1 | One-clock maskable acknowledge request |

## Verification
The halt state is driven with quiet interrupt lines, a masked maskable request, and a maskable request present only between t4 edges. These show that only a t4 sample with a valid cause ends the halt. Lone nonmaskable and maskable exits separate the two acknowledge paths. A coincident pair confirms the priority. A nonmaskable edge taken before the halt, with the line then held low across a second halt, shows that the event is remembered and is not retriggered by the level. fetch_op changes every cycle, so any leak of the fetched byte during the halt shows up on exec_op.

// File: rtl/halt_exit_ctl.sv
module halt_exit_ctl #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] NOP_CODE = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt_go,
  input  logic           nmi_n,
  input  logic           int_n,
  input  logic           int_en,
  input  logic           t4,
  input  logic [OPW-1:0] fetch_op,
  output logic [OPW-1:0] exec_op,
  output logic           halt_ack,
  output logic           force_nop,
  output logic           nmi_ack,
  output logic           int_ack
);

  logic halted, nmi_q, nmi_pend;
  logic ack_any, sample, nmi_fall;

  assign ack_any  = nmi_ack | int_ack;
  assign sample   = halted & t4 & ~ack_any;
  assign nmi_fall = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted   <= 1'b0;
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      nmi_ack  <= 1'b0;
      int_ack  <= 1'b0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= nmi_fall | (nmi_pend & ~nmi_ack);
      nmi_ack  <= sample & nmi_pend;
      int_ack  <= sample & ~nmi_pend & ~int_n & int_en;
      if (ack_any)      halted <= 1'b0;
      else if (halt_go) halted <= 1'b1;
    end
  end

  assign halt_ack  = halted;
  assign force_nop = halted;
  assign exec_op   = halted ? NOP_CODE : fetch_op;

  p_one_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_ack && int_ack));

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack || int_ack) |=> (!nmi_ack && !int_ack && !halt_ack));

  p_ack_on_t4_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_ack || int_ack) |-> ($past(t4) && $past(halt_ack)));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !nmi_pend) |=> !int_ack);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_ack && !nmi_ack && !int_ack) |=> halt_ack);

  p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_ack) |=> nmi_pend);

endmodule

// File: tb/halt_exit_ctl_tb.sv
module halt_exit_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_go = 1'b0, nmi_n = 1'b1, int_n = 1'b1, int_en = 1'b0, t4 = 1'b0;
  logic [7:0] fetch_op = 8'h00;
  logic [7:0] exec_op;
  logic halt_ack, force_nop, nmi_ack, int_ack;

  int errors = 0, checks = 0, cyc = 0;
  string req = "R1";
  bit t4_on = 1'b1;
  bit int_off_t4 = 1'b0;

  bit m_halt = 0, m_pend = 0, m_prev = 1, m_nack = 0, m_iack = 0;
  int seen_n = 0, seen_i = 0;

  always #4 clk = ~clk;

  halt_exit_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .halt_go(halt_go), .nmi_n(nmi_n), .int_n(int_n),
    .int_en(int_en), .t4(t4), .fetch_op(fetch_op), .exec_op(exec_op),
    .halt_ack(halt_ack), .force_nop(force_nop), .nmi_ack(nmi_ack), .int_ack(int_ack));

  task automatic chk(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit busy, take_n, take_i;
    if (!rst_n) begin
      m_halt = 0; m_pend = 0; m_prev = 1; m_nack = 0; m_iack = 0;
    end else begin
      busy   = m_nack || m_iack;
      take_n = m_halt && t4 && !busy && m_pend;
      take_i = m_halt && t4 && !busy && !m_pend && !int_n && int_en;
      if (busy) m_halt = 0;
      else if (halt_go) m_halt = 1;
      if (m_prev && !nmi_n) m_pend = 1;
      else if (m_nack) m_pend = 0;
      m_prev = nmi_n;
      m_nack = take_n;
      m_iack = take_i;
    end
  end

  always @(negedge clk) begin
    cyc++;
    chk(req, halt_ack, m_halt, "halt_ack");
    chk(req, force_nop, m_halt, "force_nop");
    chk(req, nmi_ack, m_nack, "nmi_ack");
    chk(req, int_ack, m_iack, "int_ack");
    chk("R3", exec_op, m_halt ? 8'h00 : fetch_op, "exec_op");
    if (nmi_ack) seen_n++;
    if (int_ack) seen_i++;
    fetch_op <= fetch_op + 8'd37;
    t4 <= t4_on && (cyc % 4 == 3);
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic halt_now();
    @(negedge clk); halt_go = 1'b1;
    @(negedge clk); halt_go = 1'b0;
  endtask

  initial begin
    fork
      begin
        run(3);
        #1; req = "R1";
        chk("R1", halt_ack, 0, "halt_ack in reset");
        chk("R1", exec_op, fetch_op, "exec_op in reset");
        rst_n = 1'b1;
        run(4);

        req = "R2"; halt_now(); #1;
        chk("R2", halt_ack, 1, "halt_ack after halt_go");
        run(12); #1;
        chk("R2", halt_ack, 1, "still halted, no interrupts");

        req = "R10"; halt_now(); run(5); #1;
        chk("R10", halt_ack, 1, "repeated halt_go");

        req = "R7"; int_n = 1'b0; int_en = 1'b0; run(12); #1;
        chk("R7", halt_ack, 1, "masked request ignored");
        chk("R7", seen_i, 0, "no int_ack when masked");

        req = "R4"; int_n = 1'b1; int_en = 1'b1; int_off_t4 = 1'b1;
        for (int i = 0; i < 16; i++) begin
          @(negedge clk); #1;
          int_n = t4 ? 1'b1 : 1'b0;
        end
        @(negedge clk); int_n = 1'b1; int_off_t4 = 1'b0; #1;
        chk("R4", halt_ack, 1, "request only off t4");

        req = "R6"; int_n = 1'b0; run(8); #1;
        chk("R6", seen_i, 1, "int_ack pulses");
        chk("R6", halt_ack, 0, "exited by maskable");
        int_n = 1'b1; int_en = 1'b0;

        req = "R5"; halt_now(); run(3); nmi_n = 1'b0; run(8); #1;
        chk("R5", seen_n, 1, "nmi_ack while int_en 0");
        chk("R5", halt_ack, 0, "exited by nonmaskable");

        req = "R9"; halt_now(); run(10); #1;
        chk("R9", seen_n, 1, "held low does not retrigger");
        chk("R9", halt_ack, 1, "held low keeps halt");
        int_en = 1'b1; int_n = 1'b0; run(8); int_n = 1'b1; int_en = 1'b0; #1;
        chk("R9", halt_ack, 0, "left via maskable");
        nmi_n = 1'b1; run(2); nmi_n = 1'b0; run(3); nmi_n = 1'b1; run(4);
        halt_now(); run(6); #1;
        chk("R9", seen_n, 2, "pending before halt exits it");

        req = "R8"; halt_now(); run(1);
        nmi_n = 1'b0; int_n = 1'b0; int_en = 1'b1; run(8); #1;
        chk("R8", seen_n, 3, "nmi wins");
        chk("R8", seen_i, 2, "no int_ack beside nmi");
        int_n = 1'b1; nmi_n = 1'b1; run(4);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule